// File: doc/BRIEF.md
# Configurable Macrocell Storage Stage

This block is one output cell of a small sum-of-products logic array. A set of static configuration inputs decides how it behaves. A polarity stage combines the incoming OR term with a constant or with product term C. The result, or a direct path from the pad buffer, feeds a single storage element. That element can act as a D flip-flop, a transparent latch, a toggle flip-flop, or a D flip-flop with enable. A feedback selector returns either the combinational result or the stored value to the interconnect.

The block runs on one fast system clock, `clk`. The selected "cell clock" comes from three global clocks, product term C, or a control-term clock. It is sampled like data on every rising edge of `clk`, and its active edges are found by comparing it with the previous sample. The cell clock can be inverted, and the flip-flop modes can capture on both of its edges. Set and reset come from selectable sources and take hold of `reg_out` at once. The power-on reset `por_n` loads a configurable start value.

The storage element is a two-state machine, ST_LO and ST_HI. On each `clk` edge it takes one of five transitions:
- TR_HOLD: keep the state.
- TR_RESET: go to ST_LO.
- TR_SET: go to ST_HI.
- TR_LOAD: take the data bit.
- TR_TOGGLE: flip ST_LO to ST_HI and ST_HI to ST_LO.

Top module: `macrocell_reg`

## Requirements
- R1: `comb_out` equals `or_term` XOR a second bit chosen by `cfg_xor_sel`: 00 gives 0, 11 gives 1, 10 gives `pt_c`, and 01 gives the inverse of `pt_c`.
- R2: When `cfg_din_direct` is 1, the storage data bit is `ibuf_in`. When it is 0, the data bit is the R1 result.
- R3: `cfg_clk_sel[1:0]` picks the cell clock: 00 picks `gclk[0]`, 10 picks `gclk[1]` and 01 picks `gclk[2]`, with bit 2 ignored for these three. Code 011 picks `pt_c` and code 111 picks `ct_clk`. Clock sources that are not picked have no effect on `reg_out`.
- R4: With `cfg_clk_inv`=0, the active edge is the rise of the cell clock and the latch is open while the cell clock is high. With `cfg_clk_inv`=1, the active edge is the fall and the latch is open while the cell clock is low. An active edge that occurs between two rises of `clk` shows on `reg_out` after the next rise of `clk`.
- R5: When `cfg_dual_edge`=1, the flip-flop modes act on both edges of the cell clock.
- R6: `cfg_mode`=00 (D flip-flop) loads the data bit on every active edge.
- R7: `cfg_mode`=01 (latch): while the latch is open, `reg_out` follows the data bit combinationally. While it is closed, `reg_out` holds the last value.
- R8: `cfg_mode`=10 (toggle) inverts the stored value on an active edge when the data bit is 1, and holds it when the data bit is 0.
- R9: `cfg_mode`=11 (D flip-flop with enable) loads on an active edge only when `ce`=1, and holds otherwise.
- R10: Reset and set sources are selected by `cfg_rst_src` and `cfg_set_src`, with the same codes for both:
  - 00 selects `pt_a`.
  - 01 selects `gsr`.
  - 10 selects `ct_rst` for reset and `ct_set` for set.
  - 11 turns the source off.
  An active reset forces `reg_out` to 0 and an active set forces it to 1, at once and without waiting for `clk`. Reset wins over set. The forced value is stored and stays after release.
- R11: When `cfg_fb_sel[0]`=1, `fb_out` is 0. Code 00 drives `fb_out` from `comb_out`, and code 10 drives it from `reg_out`.
- R12: While `por_n`=0, the stored value is `cfg_init`. The first rise of `clk` after release only records the cell clock level and never captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_mode | input | 2 | Storage mode code |
| cfg_xor_sel | input | 2 | Polarity stage second-input code |
| cfg_clk_sel | input | 3 | Cell clock source code |
| cfg_clk_inv | input | 1 | Invert cell clock |
| cfg_dual_edge | input | 1 | Capture on both cell clock edges |
| cfg_rst_src | input | 2 | Reset source code |
| cfg_set_src | input | 2 | Set source code |
| cfg_init | input | 1 | Power-on value |
| cfg_fb_sel | input | 2 | Feedback source code |
| cfg_din_direct | input | 1 | Use pad-buffer path as data |
| or_term | input | 1 | Sum-of-products input |
| pt_a | input | 1 | Product term A |
| pt_c | input | 1 | Product term C |
| gclk | input | 3 | Global clocks |
| ct_clk | input | 1 | Control-term clock |
| ct_set | input | 1 | Control-term set |
| ct_rst | input | 1 | Control-term reset |
| gsr | input | 1 | Global set/reset |
| ce | input | 1 | Clock enable |
| ibuf_in | input | 1 | Direct pad-buffer data |
| comb_out | output | 1 | Polarity stage result |
| reg_out | output | 1 | Storage element output |
| fb_out | output | 1 | Feedback to interconnect |

## Verification
A wrong stored state shows on `reg_out`, and on `fb_out` when register feedback is picked, at the first sample after the faulty `clk` edge. It stays wrong until the next load, toggle, set or reset. A wrong edge history (the previous cell clock sample or the armed flag) shows as a capture that is missing, extra or one `clk` cycle late, and it appears right after the `clk` rise that follows the cell clock change. Faults in the set/reset or latch paths show at once, in the same cycle as the input change, because those paths reach `reg_out` without a register.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
    localparam int NUM_GCLK  = 3;
    localparam int CLK_SEL_W = 3;
    localparam int CODE_W    = 2;

    typedef enum logic [CODE_W-1:0] {
        MODE_DFF    = 2'b00,
        MODE_LATCH  = 2'b01,
        MODE_TOGGLE = 2'b10,
        MODE_DFF_EN = 2'b11
    } reg_mode_e;

    typedef enum logic [CODE_W-1:0] {
        XS_ZERO  = 2'b00,
        XS_PTC_N = 2'b01,
        XS_PTC   = 2'b10,
        XS_ONE   = 2'b11
    } xor_sel_e;

    typedef enum logic [CODE_W-1:0] {
        SR_PTA    = 2'b00,
        SR_GLOBAL = 2'b01,
        SR_CTRL   = 2'b10,
        SR_OFF    = 2'b11
    } sr_src_e;

    typedef enum logic {
        ST_LO = 1'b0,
        ST_HI = 1'b1
    } store_state_e;

    typedef enum logic [2:0] {
        TR_HOLD,
        TR_RESET,
        TR_SET,
        TR_LOAD,
        TR_TOGGLE
    } xfer_e;
endpackage

// File: rtl/mc_xor_stage.sv
`timescale 1ns/1ps
module mc_xor_stage
    import mc_pkg::*;
(
    input  logic              or_term,
    input  logic              pt_c,
    input  logic [CODE_W-1:0] xor_sel,
    output logic              xor_out
);
    logic second;

    always_comb begin
        second = 1'b0;
        unique case (xor_sel_e'(xor_sel))
            XS_ZERO:  second = 1'b0;
            XS_ONE:   second = 1'b1;
            XS_PTC:   second = pt_c;
            XS_PTC_N: second = ~pt_c;
        endcase
        xor_out = or_term ^ second;
    end
endmodule

// File: rtl/mc_sr_select.sv
`timescale 1ns/1ps
module mc_sr_select
    import mc_pkg::*;
(
    input  logic [CODE_W-1:0] src,
    input  logic              pt_a,
    input  logic              gsr,
    input  logic              ctrl_term,
    output logic              active
);
    always_comb begin
        active = 1'b0;
        unique case (sr_src_e'(src))
            SR_PTA:    active = pt_a;
            SR_GLOBAL: active = gsr;
            SR_CTRL:   active = ctrl_term;
            SR_OFF:    active = 1'b0;
        endcase
    end
endmodule

// File: rtl/mc_clk_event.sv
`timescale 1ns/1ps
module mc_clk_event
    import mc_pkg::*;
(
    input  logic                 clk,
    input  logic                 por_n,
    input  logic [NUM_GCLK-1:0]  gclk,
    input  logic                 pt_c,
    input  logic                 ct_clk,
    input  logic [CLK_SEL_W-1:0] clk_sel,
    input  logic                 clk_inv,
    input  logic                 dual_edge,
    output logic                 lvl,
    output logic                 evt
);
    logic raw;
    logic prev_q;
    logic armed_q;

    // Source pick: low two bits choose a global clock, 11 defers to bit 2
    always_comb begin
        raw = gclk[0];
        unique case (clk_sel[1:0])
            2'b00: raw = gclk[0];
            2'b10: raw = gclk[1];
            2'b01: raw = gclk[2];
            2'b11: raw = clk_sel[2] ? ct_clk : pt_c;
        endcase
        lvl = raw ^ clk_inv;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= lvl;
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        if (dual_edge) evt = armed_q && (lvl != prev_q);
        else           evt = armed_q && lvl && !prev_q;
    end
endmodule

// File: rtl/mc_storage.sv
`timescale 1ns/1ps
module mc_storage
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              init_val,
    input  logic [CODE_W-1:0] mode,
    input  logic              lvl,
    input  logic              evt,
    input  logic              din,
    input  logic              ce,
    input  logic              set_act,
    input  logic              rst_act,
    output logic              q_out
);
    store_state_e state_q;
    store_state_e state_d;
    store_state_e din_state;
    xfer_e        xfer;
    reg_mode_e    mode_e;

    assign mode_e    = reg_mode_e'(mode);
    assign din_state = din ? ST_HI : ST_LO;

    always_comb begin : pick_xfer
        xfer = TR_HOLD;
        if (rst_act) begin
            xfer = TR_RESET;
        end else if (set_act) begin
            xfer = TR_SET;
        end else begin
            unique case (mode_e)
                MODE_LATCH:  if (lvl)        xfer = TR_LOAD;
                MODE_DFF:    if (evt)        xfer = TR_LOAD;
                MODE_TOGGLE: if (evt && din) xfer = TR_TOGGLE;
                MODE_DFF_EN: if (evt && ce)  xfer = TR_LOAD;
            endcase
        end
    end

    always_comb begin : next_state
        state_d = state_q;
        unique case (xfer)
            TR_HOLD:   state_d = state_q;
            TR_RESET:  state_d = ST_LO;
            TR_SET:    state_d = ST_HI;
            TR_LOAD:   state_d = din_state;
            TR_TOGGLE: begin
                unique case (state_q)
                    ST_LO: state_d = ST_HI;
                    ST_HI: state_d = ST_LO;
                endcase
            end
            default:   state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin : state_reg
        if (!por_n) state_q <= init_val ? ST_HI : ST_LO;
        else        state_q <= state_d;
    end

    // Output: set/reset and an open latch reach the pin without waiting for clk
    always_comb begin : drive_out
        if (rst_act)                            q_out = 1'b0;
        else if (set_act)                       q_out = 1'b1;
        else if ((mode_e == MODE_LATCH) && lvl) q_out = din;
        else                                    q_out = (state_q == ST_HI);
    end
endmodule

// File: rtl/macrocell_reg.sv
`timescale 1ns/1ps
module macrocell_reg
    import mc_pkg::*;
(
    input  logic                 clk,
    input  logic                 por_n,
    input  logic [CODE_W-1:0]    cfg_mode,
    input  logic [CODE_W-1:0]    cfg_xor_sel,
    input  logic [CLK_SEL_W-1:0] cfg_clk_sel,
    input  logic                 cfg_clk_inv,
    input  logic                 cfg_dual_edge,
    input  logic [CODE_W-1:0]    cfg_rst_src,
    input  logic [CODE_W-1:0]    cfg_set_src,
    input  logic                 cfg_init,
    input  logic [CODE_W-1:0]    cfg_fb_sel,
    input  logic                 cfg_din_direct,
    input  logic                 or_term,
    input  logic                 pt_a,
    input  logic                 pt_c,
    input  logic [NUM_GCLK-1:0]  gclk,
    input  logic                 ct_clk,
    input  logic                 ct_set,
    input  logic                 ct_rst,
    input  logic                 gsr,
    input  logic                 ce,
    input  logic                 ibuf_in,
    output logic                 comb_out,
    output logic                 reg_out,
    output logic                 fb_out
);
    logic xor_out;
    logic din;
    logic lvl;
    logic evt;
    logic rst_act;
    logic set_act;

    mc_xor_stage u_xor (
        .or_term (or_term),
        .pt_c    (pt_c),
        .xor_sel (cfg_xor_sel),
        .xor_out (xor_out)
    );

    mc_sr_select u_rst_sel (
        .src       (cfg_rst_src),
        .pt_a      (pt_a),
        .gsr       (gsr),
        .ctrl_term (ct_rst),
        .active    (rst_act)
    );

    mc_sr_select u_set_sel (
        .src       (cfg_set_src),
        .pt_a      (pt_a),
        .gsr       (gsr),
        .ctrl_term (ct_set),
        .active    (set_act)
    );

    mc_clk_event u_clk (
        .clk       (clk),
        .por_n     (por_n),
        .gclk      (gclk),
        .pt_c      (pt_c),
        .ct_clk    (ct_clk),
        .clk_sel   (cfg_clk_sel),
        .clk_inv   (cfg_clk_inv),
        .dual_edge (cfg_dual_edge),
        .lvl       (lvl),
        .evt       (evt)
    );

    assign din = cfg_din_direct ? ibuf_in : xor_out;

    mc_storage u_store (
        .clk      (clk),
        .por_n    (por_n),
        .init_val (cfg_init),
        .mode     (cfg_mode),
        .lvl      (lvl),
        .evt      (evt),
        .din      (din),
        .ce       (ce),
        .set_act  (set_act),
        .rst_act  (rst_act),
        .q_out    (reg_out)
    );

    assign comb_out = xor_out;

    always_comb begin
        fb_out = 1'b0;
        if (!cfg_fb_sel[0]) fb_out = cfg_fb_sel[1] ? reg_out : xor_out;
    end
endmodule

// File: rtl/mc_reg_checker.sv
`timescale 1ns/1ps
module mc_reg_checker (
    input logic       clk,
    input logic       por_n,
    input logic [1:0] cfg_rst_src,
    input logic [1:0] cfg_set_src,
    input logic [1:0] cfg_mode,
    input logic [1:0] cfg_fb_sel,
    input logic       pt_a,
    input logic       gsr,
    input logic       ct_set,
    input logic       ct_rst,
    input logic       ce,
    input logic       comb_out,
    input logic       reg_out,
    input logic       fb_out
);
    logic rst_any;
    logic set_any;

    always_comb begin
        rst_any = ((cfg_rst_src == 2'b00) && pt_a) || ((cfg_rst_src == 2'b01) && gsr) ||
                  ((cfg_rst_src == 2'b10) && ct_rst);
        set_any = ((cfg_set_src == 2'b00) && pt_a) || ((cfg_set_src == 2'b01) && gsr) ||
                  ((cfg_set_src == 2'b10) && ct_set);
    end

    p_reset_wins_r10: assert property (@(posedge clk) disable iff (!por_n)
        rst_any |-> !reg_out);

    p_set_forces_r10: assert property (@(posedge clk) disable iff (!por_n)
        (set_any && !rst_any) |-> reg_out);

    p_fb_off_r11: assert property (@(posedge clk) disable iff (!por_n)
        cfg_fb_sel[0] |-> !fb_out);

    p_fb_reg_r11: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_fb_sel == 2'b10) |-> (fb_out == reg_out));

    p_fb_comb_r11: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_fb_sel == 2'b00) |-> (fb_out == comb_out));

    p_ce_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        ((cfg_mode == 2'b11) && !ce && !set_any && !rst_any)
        |=> ((cfg_mode != 2'b11) || set_any || rst_any || $stable(reg_out)));
endmodule

bind macrocell_reg mc_reg_checker u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .cfg_rst_src (cfg_rst_src),
    .cfg_set_src (cfg_set_src),
    .cfg_mode    (cfg_mode),
    .cfg_fb_sel  (cfg_fb_sel),
    .pt_a        (pt_a),
    .gsr         (gsr),
    .ct_set      (ct_set),
    .ct_rst      (ct_rst),
    .ce          (ce),
    .comb_out    (comb_out),
    .reg_out     (reg_out),
    .fb_out      (fb_out)
);

// File: tb/macrocell_reg_test.sv
`timescale 1ns/1ps
module macrocell_reg_test;
    logic       clk = 1'b0;
    logic       por_n;
    logic [1:0] cfg_mode, cfg_xor_sel, cfg_rst_src, cfg_set_src, cfg_fb_sel;
    logic [2:0] cfg_clk_sel;
    logic       cfg_clk_inv, cfg_dual_edge, cfg_init, cfg_din_direct;
    logic       or_term, pt_a, pt_c, ct_clk, ct_set, ct_rst, gsr, ce, ibuf_in;
    logic [2:0] gclk;
    logic       comb_out, reg_out, fb_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    bit q_m, prev_m, armed_m;

    always #2.5 clk = ~clk;

    macrocell_reg uut (
        .clk(clk), .por_n(por_n), .cfg_mode(cfg_mode), .cfg_xor_sel(cfg_xor_sel),
        .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv), .cfg_dual_edge(cfg_dual_edge),
        .cfg_rst_src(cfg_rst_src), .cfg_set_src(cfg_set_src), .cfg_init(cfg_init),
        .cfg_fb_sel(cfg_fb_sel), .cfg_din_direct(cfg_din_direct), .or_term(or_term),
        .pt_a(pt_a), .pt_c(pt_c), .gclk(gclk), .ct_clk(ct_clk), .ct_set(ct_set),
        .ct_rst(ct_rst), .gsr(gsr), .ce(ce), .ibuf_in(ibuf_in),
        .comb_out(comb_out), .reg_out(reg_out), .fb_out(fb_out)
    );

    function automatic bit f_xor(bit o, bit c, bit [1:0] s);
        case (s)
            2'b00:   return o;
            2'b11:   return !o;
            2'b10:   return o ^ c;
            default: return o ^ !c;
        endcase
    endfunction

    function automatic bit f_lvl(bit [2:0] s, bit [2:0] g, bit c, bit t, bit inv);
        bit r;
        if (s[1:0] == 2'b00)      r = g[0];
        else if (s[1:0] == 2'b10) r = g[1];
        else if (s[1:0] == 2'b01) r = g[2];
        else                      r = s[2] ? t : c;
        return r ^ inv;
    endfunction

    function automatic bit f_sr(bit [1:0] s, bit a, bit g, bit t);
        case (s)
            2'b00:   return a;
            2'b01:   return g;
            2'b10:   return t;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input logic act, input bit exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Called just after a falling clk edge with inputs already set
    task automatic step();
        bit x, d, lv, r, s, er, efb, ev, qn;
        string tag;
        #1;
        x  = f_xor(or_term, pt_c, cfg_xor_sel);
        d  = cfg_din_direct ? ibuf_in : x;
        lv = f_lvl(cfg_clk_sel, gclk, pt_c, ct_clk, cfg_clk_inv);
        r  = f_sr(cfg_rst_src, pt_a, gsr, ct_rst);
        s  = f_sr(cfg_set_src, pt_a, gsr, ct_set);
        if (r)                          er = 1'b0;
        else if (s)                     er = 1'b1;
        else if (cfg_mode == 2'b01 && lv) er = d;
        else                            er = q_m;
        efb = cfg_fb_sel[0] ? 1'b0 : (cfg_fb_sel[1] ? er : x);
        if (r || s) tag = "R10";
        else case (cfg_mode)
            2'b00:   tag = "R6";
            2'b01:   tag = "R7";
            2'b10:   tag = "R8";
            default: tag = "R9";
        endcase
        check(comb_out, x, "R1", "comb_out");
        check(reg_out, er, tag, "reg_out");
        check(fb_out, efb, "R11", "fb_out");
        ev = armed_m && (cfg_dual_edge ? (lv != prev_m) : (lv && !prev_m));
        if (r)      qn = 1'b0;
        else if (s) qn = 1'b1;
        else case (cfg_mode)
            2'b01:   qn = lv ? d : q_m;
            2'b00:   qn = ev ? d : q_m;
            2'b10:   qn = (ev && d) ? !q_m : q_m;
            default: qn = (ev && ce) ? d : q_m;
        endcase
        @(posedge clk);
        #1;
        q_m = qn;
        prev_m = lv;
        armed_m = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_por(input bit iv);
        por_n = 1'b0;
        cfg_init = iv;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        q_m = iv;
        prev_m = 1'b0;
        armed_m = 1'b0;
    endtask

    task automatic drive_src(input int idx, input bit v);
        case (idx)
            0: gclk[0] = v;
            1: gclk[1] = v;
            2: gclk[2] = v;
            3: pt_c = v;
            default: ct_clk = v;
        endcase
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        bit [2:0] codes [5];
        int seed;
        codes = '{3'b000, 3'b010, 3'b001, 3'b011, 3'b111};
        seed = $urandom(32'd2024);
        cfg_mode = 2'b00; cfg_xor_sel = 2'b00; cfg_clk_sel = 3'b000; cfg_clk_inv = 0;
        cfg_dual_edge = 0; cfg_rst_src = 2'b11; cfg_set_src = 2'b11; cfg_fb_sel = 2'b01;
        cfg_din_direct = 0; or_term = 0; pt_a = 0; pt_c = 0; ct_clk = 0; ct_set = 0;
        ct_rst = 0; gsr = 0; ce = 0; ibuf_in = 0; gclk = 3'b000;

        // R12: power-on value
        do_por(1'b1);
        check(reg_out, 1'b1, "R12", "init one");
        step();
        check(reg_out, 1'b1, "R12", "no edge keeps init");
        do_por(1'b0);
        check(reg_out, 1'b0, "R12", "init zero");
        // R12: first sample after release only arms edge detection
        gclk[0] = 1'b1; or_term = 1'b1;
        do_por(1'b0);
        step();
        check(reg_out, 1'b0, "R12", "no capture on first sample");
        gclk[0] = 1'b0; step();
        gclk[0] = 1'b1; step();
        check(reg_out, 1'b1, "R6", "dff capture");
        gclk[0] = 1'b0; step();

        // R3: each source code, unselected sources ignored; R4 falling edge ignored
        for (int k = 0; k < 5; k++) begin
            gclk = 3'b000; pt_c = 0; ct_clk = 0;
            cfg_clk_sel = codes[k]; or_term = 1'b1;
            cfg_rst_src = 2'b10; ct_rst = 1'b1; step();
            ct_rst = 1'b0; cfg_rst_src = 2'b11; step();
            drive_src((k + 1) % 5, 1'b1); step();
            check(reg_out, 1'b0, "R3", "unselected source ignored");
            drive_src((k + 1) % 5, 1'b0); step();
            drive_src(k, 1'b1); step();
            check(reg_out, 1'b1, "R3", "selected source captures");
            or_term = 1'b0; drive_src(k, 1'b0); step();
            check(reg_out, 1'b1, "R4", "falling edge ignored");
        end
        gclk = 3'b000; pt_c = 0; ct_clk = 0; cfg_clk_sel = 3'b000;

        // R4: inverted polarity
        cfg_clk_inv = 1'b1; gclk[0] = 1'b1; step(); step();
        or_term = 1'b1; gclk[0] = 1'b0; step();
        check(reg_out, 1'b1, "R4", "inverted captures on fall");
        or_term = 1'b0; gclk[0] = 1'b1; step();
        check(reg_out, 1'b1, "R4", "inverted ignores rise");
        gclk[0] = 1'b0; cfg_clk_inv = 1'b0; step(); step();

        // R5: dual edge
        cfg_dual_edge = 1'b1;
        or_term = 1'b1; gclk[0] = 1'b1; step();
        check(reg_out, 1'b1, "R5", "dual rise");
        or_term = 1'b0; gclk[0] = 1'b0; step();
        check(reg_out, 1'b0, "R5", "dual fall");
        cfg_dual_edge = 1'b0;

        // R2: direct pad path
        cfg_din_direct = 1'b1; ibuf_in = 1'b1; or_term = 1'b0; gclk[0] = 1'b1; step();
        check(reg_out, 1'b1, "R2", "direct path stored");
        check(comb_out, 1'b0, "R2", "comb unaffected");
        gclk[0] = 1'b0; cfg_din_direct = 1'b0; ibuf_in = 1'b0; step();

        // R8: toggle
        cfg_mode = 2'b10; or_term = 1'b1; gclk[0] = 1'b1; step();
        check(reg_out, 1'b0, "R8", "toggle flips");
        gclk[0] = 1'b0; step();
        gclk[0] = 1'b1; step();
        check(reg_out, 1'b1, "R8", "toggle flips back");
        gclk[0] = 1'b0; or_term = 1'b0; step();
        gclk[0] = 1'b1; step();
        check(reg_out, 1'b1, "R8", "toggle holds on zero");
        gclk[0] = 1'b0; step();

        // R9: enable
        cfg_mode = 2'b11; ce = 1'b0; gclk[0] = 1'b1; step();
        check(reg_out, 1'b1, "R9", "enable low holds");
        gclk[0] = 1'b0; step();
        ce = 1'b1; gclk[0] = 1'b1; step();
        check(reg_out, 1'b0, "R9", "enable high loads");
        gclk[0] = 1'b0; ce = 1'b0; step();

        // R7: latch
        cfg_mode = 2'b01; or_term = 1'b1;
        #1 check(reg_out, 1'b0, "R7", "closed latch holds");
        step();
        gclk[0] = 1'b1;
        #1 check(reg_out, 1'b1, "R7", "open latch passes at once");
        step();
        or_term = 1'b0;
        #1 check(reg_out, 1'b0, "R7", "open latch follows");
        step();
        or_term = 1'b1; step();
        gclk[0] = 1'b0; step();
        or_term = 1'b0;
        #1 check(reg_out, 1'b1, "R7", "latch keeps after close");
        step();

        // R10: set/reset sources and priority
        cfg_mode = 2'b00; cfg_rst_src = 2'b10; cfg_set_src = 2'b10;
        ct_set = 1'b0; step();
        ct_rst = 1'b1;
        #1 check(reg_out, 1'b0, "R10", "ctrl reset immediate");
        step();
        ct_rst = 1'b0; ct_set = 1'b1;
        #1 check(reg_out, 1'b1, "R10", "ctrl set immediate");
        step();
        ct_rst = 1'b1;
        #1 check(reg_out, 1'b0, "R10", "reset wins over set");
        step();
        ct_rst = 1'b0; ct_set = 1'b0; step();
        check(reg_out, 1'b0, "R10", "reset value kept");
        cfg_rst_src = 2'b11; cfg_set_src = 2'b00; pt_a = 1'b1;
        #1 check(reg_out, 1'b1, "R10", "pt_a as set");
        step();
        pt_a = 1'b0; cfg_set_src = 2'b11; cfg_rst_src = 2'b01; gsr = 1'b1;
        #1 check(reg_out, 1'b0, "R10", "gsr as reset");
        step();
        gsr = 1'b0; cfg_rst_src = 2'b11; step();

        // R11: feedback select
        cfg_fb_sel = 2'b00; or_term = 1'b1;
        #1 check(fb_out, 1'b1, "R11", "fb from comb");
        step();
        cfg_fb_sel = 2'b11;
        #1 check(fb_out, 1'b0, "R11", "fb disabled");
        step();
        cfg_fb_sel = 2'b10;
        #1 check(fb_out, reg_out, "R11", "fb from register");
        step();

        // Constrained random
        for (int seg = 0; seg < 60; seg++) begin
            cfg_mode = 2'($urandom); cfg_xor_sel = 2'($urandom);
            cfg_clk_sel = 3'($urandom); cfg_clk_inv = 1'($urandom);
            cfg_dual_edge = 1'($urandom); cfg_rst_src = 2'($urandom);
            cfg_set_src = 2'($urandom); cfg_fb_sel = 2'($urandom);
            cfg_din_direct = 1'($urandom);
            if (seg % 10 == 0) do_por(1'($urandom));
            for (int i = 0; i < 40; i++) begin
                for (int b = 0; b < 3; b++) if ($urandom % 3 == 0) gclk[b] = !gclk[b];
                if ($urandom % 3 == 0) pt_c = !pt_c;
                if ($urandom % 3 == 0) ct_clk = !ct_clk;
                or_term = 1'($urandom); ibuf_in = 1'($urandom); ce = 1'($urandom);
                pt_a = ($urandom % 8 == 0); gsr = ($urandom % 16 == 0);
                ct_set = ($urandom % 8 == 0); ct_rst = ($urandom % 8 == 0);
                step();
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule